// File: doc/BRIEF.md
# Display Video Timing Generator

This block produces the raster timing for a serial display link that runs in video mode. From a set of programmable lengths it generates horizontal sync, vertical sync, data enable, and a blanking indicator for each axis. Each axis has its own horizontal or vertical length set. A separate flag says whether the link may fall back to low-power signalling in the current interval. A second flag says whether a command may be sent during that low-power time. The block also presents the chosen pixel colour depth and the number of pixels per video packet. These two outputs are read by the packetiser downstream. The block carries no pixel data. It only marks where packets and low-power intervals may go.

Software writes a shadow register set through a simple write port. The generator runs from an active copy of that set. The active copy is refreshed while the generator is disabled and again at each frame boundary, so a frame never mixes two configurations.

Each axis is driven by one state machine with four named states: SYNC, BACK, ACTIVE and FRONT. The transitions are:
- SYNC→BACK when the sync length has elapsed.
- BACK→ACTIVE when the back-porch length has elapsed.
- ACTIVE→FRONT when the active length has elapsed.
- FRONT→SYNC at the wrap. For the horizontal axis the wrap comes at the programmed line total. For the vertical axis it comes after the front-porch lines.

While disabled, both machines are held in SYNC with their counters at zero.

Top module: `dtg_timing_gen`

## Requirements
- R1: While `en` is low, every output sits at its inactive level: `hsync`, `vsync` and `de` equal their polarity bits, and `hblank`, `vblank`, `lp_ok` and `cmd_lp_ok` are 0. The counters are held at zero, so the first enabled cycle is pixel 0 of line 0, which is the start of sync.
- R2: Let h be the pixel position in the line, counted from 0 at the first enabled cycle and wrapping at the line total T. The horizontal region is:
  - sync for h < S;
  - back porch for the next B pixels;
  - active for the next A pixels;
  - front porch from there up to T-1.
  The front porch therefore has T-S-B-A pixels.
- R3: Lines advance at the end of each line. The vertical region order is sync lines, back-porch lines, active lines and front-porch lines, after which the frame wraps.
- R4: Data enable is asserted only in active pixels of active lines. When enabled, `hblank` is high outside the horizontal active region and `vblank` is high outside the vertical active region.
- R5: Polarity register bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts data enable. Each output equals its active-high value XOR its bit.
- R6: The low-power permission register assigns one bit to each interval:

  | Bit | Interval |
  |---|---|
  | 0 | vertical sync lines |
  | 1 | vertical back-porch lines |
  | 2 | vertical front-porch lines |
  | 3 | non-active, non-front-porch pixels of active lines |
  | 4 | horizontal front porch of active lines |

  `lp_ok` is never high during active pixels.
- R7: `cmd_lp_ok` is high exactly when `lp_ok` is high and bit 5 of the low-power permission register is set.
- R8: A register write takes effect at the next frame start, or during the next cycle in which `en` is low. A write made mid-frame leaves the running frame unchanged.
- R9: The colour-depth code selects the `color_bits` value: 0 gives 16, 1 gives 24, 2 gives 30, and 3 falls back to 24.
- R10: After reset, `pkt_pixels` reads 1200 and `color_bits` reads 24. `pkt_pixels` follows the packet-size register.
- R11: The write addresses are:

  | Address | Register |
  |---|---|
  | 0 | sync width |
  | 1 | back porch |
  | 2 | active width |
  | 3 | line total |
  | 4 | vertical sync lines |
  | 5 | vertical back-porch lines |
  | 6 | active lines |
  | 7 | front-porch lines |
  | 8 | polarity |
  | 9 | low-power permission |
  | 10 | colour code |
  | 11 | packet size |

  Each field takes the low bits of `wr_data`. All lengths must be at least 1, and the line total must exceed S+B+A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low holds the counters and idles the outputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable, polarity applied |
| hblank | output | 1 | Outside horizontal active region |
| vblank | output | 1 | Outside vertical active region |
| lp_ok | output | 1 | Low-power signalling permitted now |
| cmd_lp_ok | output | 1 | Command transfer in low power permitted now |
| color_bits | output | 5 | Bits per pixel: 16, 24 or 30 |
| pkt_pixels | output | 16 | Pixels per video packet |

## Verification
The hardest situation to reach from the ports is a register write that lands during a running frame, especially one whose write edge coincides with the frame-boundary edge. The active copy must then take the old shadow value, and the new value only at the following boundary. The bench issues writes at several positions inside an enabled frame, including the final pixel of the last line. Its model applies the load before the shadow update at each edge, so any early adoption shows up as a timing or polarity miscompare. A sweep over many small line and frame shapes covers the corner lengths of one pixel and one line in each region.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int CW  = 12;   // length field width
    localparam int DW  = 16;   // write data width
    localparam int AW  = 4;    // write address width
    localparam int PW  = 3;    // polarity field width
    localparam int LW  = 6;    // low-power permission field width

    // low-power permission bit positions
    localparam int LP_VSYNC = 0;
    localparam int LP_VBACK = 1;
    localparam int LP_VFRNT = 2;
    localparam int LP_VACT  = 3;
    localparam int LP_HFRNT = 4;
    localparam int LP_CMD   = 5;

    typedef enum logic [1:0] {
        RG_SYNC   = 2'd0,
        RG_BACK   = 2'd1,
        RG_ACTIVE = 2'd2,
        RG_FRONT  = 2'd3
    } region_t;

    typedef struct packed {
        logic [CW-1:0] h_sync;
        logic [CW-1:0] h_back;
        logic [CW-1:0] h_act;
        logic [CW-1:0] h_total;
        logic [CW-1:0] v_sync;
        logic [CW-1:0] v_back;
        logic [CW-1:0] v_act;
        logic [CW-1:0] v_front;
        logic [PW-1:0] pol;
        logic [LW-1:0] lp;
        logic [1:0]    color;
        logic [DW-1:0] pkt;
    } dtg_cfg_t;

    function automatic logic [4:0] depth_bits(input logic [1:0] code);
        logic [4:0] r;
        unique case (code)
            2'd0:    r = 5'd16;
            2'd2:    r = 5'd30;
            default: r = 5'd24;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
    import dtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          load,
    output dtg_cfg_t      active
);

    localparam dtg_cfg_t CFG_RST = '{
        h_sync:  CW'(2), h_back: CW'(2), h_act: CW'(8), h_total: CW'(16),
        v_sync:  CW'(1), v_back: CW'(1), v_act: CW'(4), v_front: CW'(1),
        pol:     '0,     lp:     '0,     color: 2'd1,   pkt:     DW'(1200)
    };

    dtg_cfg_t shadow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= CFG_RST;
        end else if (wr_en) begin
            case (wr_addr)
                AW'(0):  shadow.h_sync  <= wr_data[CW-1:0];
                AW'(1):  shadow.h_back  <= wr_data[CW-1:0];
                AW'(2):  shadow.h_act   <= wr_data[CW-1:0];
                AW'(3):  shadow.h_total <= wr_data[CW-1:0];
                AW'(4):  shadow.v_sync  <= wr_data[CW-1:0];
                AW'(5):  shadow.v_back  <= wr_data[CW-1:0];
                AW'(6):  shadow.v_act   <= wr_data[CW-1:0];
                AW'(7):  shadow.v_front <= wr_data[CW-1:0];
                AW'(8):  shadow.pol     <= wr_data[PW-1:0];
                AW'(9):  shadow.lp      <= wr_data[LW-1:0];
                AW'(10): shadow.color   <= wr_data[1:0];
                AW'(11): shadow.pkt     <= wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    active <= CFG_RST;
        else if (load) active <= shadow;
    end

endmodule

// File: rtl/dtg_region_seq.sv
module dtg_region_seq
    import dtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic [CW-1:0] len_sync,
    input  logic [CW-1:0] len_back,
    input  logic [CW-1:0] len_active,
    input  logic [CW-1:0] len_total,
    output region_t       region,
    output logic          wrap
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] pos, pos_nx;
    logic [CW-1:0] edge_back, edge_act, edge_front;
    region_t       region_nx;

    always_comb begin
        edge_back  = len_sync;
        edge_act   = len_sync + len_back;
        edge_front = edge_act + len_active;
        pos_nx     = pos + ONE;
        wrap       = run && step && (pos == len_total - ONE);
    end

    always_comb begin
        region_nx = region;
        unique case (region)
            RG_SYNC:   if (pos_nx == edge_back)  region_nx = RG_BACK;
            RG_BACK:   if (pos_nx == edge_act)   region_nx = RG_ACTIVE;
            RG_ACTIVE: if (pos_nx == edge_front) region_nx = RG_FRONT;
            RG_FRONT:  region_nx = RG_FRONT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            region <= RG_SYNC;
            pos    <= '0;
        end else if (!run) begin
            region <= RG_SYNC;
            pos    <= '0;
        end else if (wrap) begin
            region <= RG_SYNC;
            pos    <= '0;
        end else if (step) begin
            region <= region_nx;
            pos    <= pos_nx;
        end
    end

endmodule

// File: rtl/dtg_timing_gen.sv
module dtg_timing_gen
    import dtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          hblank,
    output logic          vblank,
    output logic          lp_ok,
    output logic          cmd_lp_ok,
    output logic [4:0]    color_bits,
    output logic [DW-1:0] pkt_pixels
);

    dtg_cfg_t      cfg;
    region_t       hreg, vreg;
    logic          line_end, frame_end;
    logic [CW-1:0] v_total;
    logic          lp_raw;

    assign v_total = cfg.v_sync + cfg.v_back + cfg.v_act + cfg.v_front;

    dtg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (!en || frame_end),
        .active  (cfg)
    );

    dtg_region_seq u_hseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (en),
        .step       (1'b1),
        .len_sync   (cfg.h_sync),
        .len_back   (cfg.h_back),
        .len_active (cfg.h_act),
        .len_total  (cfg.h_total),
        .region     (hreg),
        .wrap       (line_end)
    );

    dtg_region_seq u_vseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (en),
        .step       (line_end),
        .len_sync   (cfg.v_sync),
        .len_back   (cfg.v_back),
        .len_active (cfg.v_act),
        .len_total  (v_total),
        .region     (vreg),
        .wrap       (frame_end)
    );

    always_comb begin
        lp_raw = 1'b0;
        unique case (vreg)
            RG_SYNC:   lp_raw = cfg.lp[LP_VSYNC];
            RG_BACK:   lp_raw = cfg.lp[LP_VBACK];
            RG_FRONT:  lp_raw = cfg.lp[LP_VFRNT];
            RG_ACTIVE: begin
                if (hreg == RG_FRONT)       lp_raw = cfg.lp[LP_HFRNT];
                else if (hreg != RG_ACTIVE) lp_raw = cfg.lp[LP_VACT];
            end
        endcase
        hsync      = (en && hreg == RG_SYNC) ^ cfg.pol[0];
        vsync      = (en && vreg == RG_SYNC) ^ cfg.pol[1];
        de         = (en && hreg == RG_ACTIVE && vreg == RG_ACTIVE) ^ cfg.pol[2];
        hblank     = en && hreg != RG_ACTIVE;
        vblank     = en && vreg != RG_ACTIVE;
        lp_ok      = en && lp_raw;
        cmd_lp_ok  = en && lp_raw && cfg.lp[LP_CMD];
        color_bits = depth_bits(cfg.color);
        pkt_pixels = cfg.pkt;
    end

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
    import dtg_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     en,
    input logic     hsync,
    input logic     vsync,
    input logic     de,
    input logic     hblank,
    input logic     vblank,
    input logic     lp_ok,
    input logic     cmd_lp_ok,
    input dtg_cfg_t cfg,
    input region_t  hreg,
    input region_t  vreg,
    input logic     line_end,
    input logic     frame_end
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!hblank && !vblank && !lp_ok && hsync == cfg.pol[0]
                 && vsync == cfg.pol[1] && de == cfg.pol[2]));

    p_start_in_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (hreg == RG_SYNC && vreg == RG_SYNC));

    p_line_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && vreg != $past(vreg)) |-> $past(line_end));

    p_de_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (hblank || vblank)) |-> de == cfg.pol[2]);

    p_cmd_needs_lp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_lp_ok |-> lp_ok);

    p_cfg_frame_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$past(frame_end)) |-> cfg == $past(cfg));

endmodule

bind dtg_timing_gen dtg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .hsync     (hsync),
    .vsync     (vsync),
    .de        (de),
    .hblank    (hblank),
    .vblank    (vblank),
    .lp_ok     (lp_ok),
    .cmd_lp_ok (cmd_lp_ok),
    .cfg       (cfg),
    .hreg      (hreg),
    .vreg      (vreg),
    .line_end  (line_end),
    .frame_end (frame_end)
);

// File: tb/dtg_timing_gen_test.sv
`timescale 1ns/1ps
module dtg_timing_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_b = 1'b0;
    logic        we_b = 1'b0;
    logic [3:0]  wa_b = '0;
    logic [15:0] wd_b = '0;
    logic        hsync, vsync, de, hblank, vblank, lp_ok, cmd_lp_ok;
    logic [4:0]  color_bits;
    logic [15:0] pkt_pixels;

    int vectors = 0;
    int fails = 0;
    int sh[12];
    int ac[12];
    int h = 0;
    int l = 0;
    string ctx = "";

    always #2 clk = ~clk;

    dtg_timing_gen uut (
        .clk(clk), .rst_n(rst_n), .en(en_b), .wr_en(we_b), .wr_addr(wa_b),
        .wr_data(wd_b), .hsync(hsync), .vsync(vsync), .de(de), .hblank(hblank),
        .vblank(vblank), .lp_ok(lp_ok), .cmd_lp_ok(cmd_lp_ok),
        .color_bits(color_bits), .pkt_pixels(pkt_pixels)
    );

    function automatic int fmask(int a, int d);
        if (a <= 7)  return d & 12'hFFF;
        if (a == 8)  return d & 7;
        if (a == 9)  return d & 63;
        if (a == 10) return d & 3;
        return d & 16'hFFFF;
    endfunction

    function automatic int region_of(int p, int s, int b, int a);
        if (p < s)         return 0;
        if (p < s + b)     return 1;
        if (p < s + b + a) return 2;
        return 3;
    endfunction

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (h=%0d l=%0d)",
                     tag, ctx, act, exp, h, l);
        end
    endtask

    task automatic check_all();
        int hr, vr, pol, lp, hs_a, vs_a, de_a, lp_a, col;
        pol = ac[8];
        lp  = ac[9];
        hr = region_of(h, ac[0], ac[1], ac[2]);
        vr = region_of(l, ac[4], ac[5], ac[6]);
        hs_a = (en_b && hr == 0) ? 1 : 0;
        vs_a = (en_b && vr == 0) ? 1 : 0;
        de_a = (en_b && hr == 2 && vr == 2) ? 1 : 0;
        case (vr)
            0: lp_a = lp & 1;
            1: lp_a = (lp >> 1) & 1;
            3: lp_a = (lp >> 2) & 1;
            default: lp_a = (hr == 3) ? ((lp >> 4) & 1) : (hr == 2) ? 0 : ((lp >> 3) & 1);
        endcase
        if (!en_b) lp_a = 0;
        col = (ac[10] == 0) ? 16 : (ac[10] == 2) ? 30 : 24;
        if (!en_b) begin
            chk("R1 hsync", hsync, pol & 1);
            chk("R1 vsync", vsync, (pol >> 1) & 1);
            chk("R1 de", de, (pol >> 2) & 1);
            chk("R1 blank", {hblank, vblank}, 0);
            chk("R1 lp", {lp_ok, cmd_lp_ok}, 0);
        end else begin
            chk("R2 R5 hsync", hsync, hs_a ^ (pol & 1));
            chk("R3 R5 vsync", vsync, vs_a ^ ((pol >> 1) & 1));
            chk("R4 R5 de", de, de_a ^ ((pol >> 2) & 1));
            chk("R4 hblank", hblank, (hr != 2) ? 1 : 0);
            chk("R4 vblank", vblank, (vr != 2) ? 1 : 0);
            chk("R6 lp_ok", lp_ok, lp_a);
            chk("R7 cmd_lp_ok", cmd_lp_ok, lp_a & ((lp >> 5) & 1));
        end
        chk("R9 color_bits", color_bits, col);
        chk("R10 pkt_pixels", pkt_pixels, ac[11]);
    endtask

    task automatic step(input logic e, input logic w, input int a, input int d);
        int vtot;
        logic fe;
        @(negedge clk);
        check_all();
        en_b = e; we_b = w; wa_b = 4'(a); wd_b = 16'(d);
        @(posedge clk);
        vtot = ac[4] + ac[5] + ac[6] + ac[7];
        fe = e && (h == ac[3] - 1) && (l == vtot - 1);
        if (!e) begin
            h = 0; l = 0;
        end else begin
            h++;
            if (h == ac[3]) begin
                h = 0;
                l++;
                if (l == vtot) l = 0;
            end
        end
        if (!e || fe) ac = sh;
        if (w && a < 12) sh[a] = fmask(a, d);
    endtask

    task automatic run(input int n, input logic e);
        for (int i = 0; i < n; i++) step(e, 1'b0, 0, 0);
    endtask

    task automatic wr(input int a, input int d);
        step(en_b, 1'b1, a, d);
    endtask

    task automatic setup(input int hs, input int hb, input int ha, input int hf,
                         input int vs, input int vb, input int va, input int vf,
                         input int pol, input int lp, input int col);
        wr(0, hs); wr(1, hb); wr(2, ha); wr(3, hs + hb + ha + hf);
        wr(4, vs); wr(5, vb); wr(6, va); wr(7, vf);
        wr(8, pol); wr(9, lp); wr(10, col);
    endtask

    function automatic int frame_len();
        return ac[3] * (ac[4] + ac[5] + ac[6] + ac[7]);
    endfunction

    initial begin
        sh = '{2, 2, 8, 16, 1, 1, 4, 1, 0, 0, 1, 1200};
        ac = sh;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset defaults and idle outputs
        ctx = "reset";
        run(4, 1'b0);

        // default configuration running (R2 R3 R4)
        ctx = "default";
        run(2 * frame_len() + 3, 1'b1);

        // configuration A: all low-power bits, normal polarity (R6 R7)
        ctx = "cfgA";
        run(1, 1'b0);
        setup(2, 3, 5, 3, 2, 1, 3, 2, 0, 63, 2);
        run(2, 1'b0);
        run(2 * frame_len(), 1'b1);

        // configuration B: minimal lengths, inverted polarity, partial low-power (R5 R9)
        ctx = "cfgB";
        run(1, 1'b0);
        setup(1, 1, 1, 1, 1, 1, 1, 1, 5, 6'b010110, 0);
        run(2, 1'b0);
        run(3 * frame_len(), 1'b1);

        // mid-frame writes while running (R8), including the frame-boundary edge
        ctx = "R8 mid-frame update";
        run(1, 1'b0);
        setup(2, 2, 3, 2, 1, 2, 2, 1, 0, 6'b101001, 1);
        run(2, 1'b0);
        run(7, 1'b1);
        wr(3, 11);
        wr(8, 3);
        wr(10, 2);
        wr(11, 640);
        run(frame_len() - 11 - 1, 1'b1);
        wr(8, 6);                 // lands on the frame-boundary edge
        run(frame_len() + 5, 1'b1);
        wr(10, 3);                // fallback depth code
        run(2 * frame_len() + 20, 1'b1);

        // sweep of small shapes (R2 R3 R4 R6 R11)
        ctx = "R11 sweep";
        for (int i = 0; i < 48; i++) begin
            run(1, 1'b0);
            setup(1 + (i % 2), 1 + ((i / 2) % 2), 1 + ((i / 4) % 3), 1 + ((i / 12) % 2),
                  1 + (i % 3), 1 + ((i / 3) % 2), 1 + ((i / 6) % 2), 1 + ((i / 24) % 2),
                  i % 8, (i * 11) % 64, i % 4);
            run(2, 1'b0);
            run(2 * frame_len() + 1, 1'b1);
        end

        ctx = "end";
        run(2, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule